// File: doc/BRIEF.md
# Thermal Proportional-Integral Scaling Controller

This block is a closed-loop thermal governor. Each time a sampling strobe arrives, it picks the hottest of several on-chip temperature readings and subtracts a programmable trip temperature to form a signed error. A proportional-integral update with a fixed gain of 10 turns that error into a demand, which is clamped to a fixed range. An exponential average with a one-quarter weight smooths the demand. The smoothed value is then quantised to a 4-bit scaling level that goes to the voltage/frequency regulator.

Level code 0 selects full nominal voltage. Code 15 selects half of nominal. The codes in between are spaced evenly, about 3.33 % of nominal per code. The system is expected to pulse the strobe once every 10,000 clock cycles. A single strobe starts a fixed sequence of states:

- S_IDLE waits for a strobe and captures the error.
- S_PI updates the demand and the integrator.
- S_FILT updates the average.
- S_QUANT loads the level and the engaged flag, then the sequence returns to S_IDLE.

The enable input gates the whole loop. When enable is low the loop is held cleared and returns to S_IDLE.

Top module: `thermal_pi_ctrl`

## Requirements
- R1: After reset the level output is 0 and the engaged flag is low.
- R2: The temperature used is the largest of the N_SENS unsigned 8-bit readings on the packed temperature bus, with sensor k at bits [8k+7:8k]. Readings below the maximum have no effect on the result.
- R3: The error is hottest reading minus threshold, in whole degrees. The demand is 10 times the error plus the integrator value before this sample. The demand is clamped to the range 0 to 240, where 240 is 16 times code 15.
- R4: The integrator is held unchanged when the clamped demand of the previous sample was 240 and the error is positive. It is also held when that demand was 0 and the error is negative. In all other cases the integrator becomes integrator plus error, saturated to 0..240.
- R5: The average moves toward the new clamped demand by one quarter of the difference. The step is rounded up when rising and rounded down when falling, so the average reaches the demand exactly.
- R6: The level is the average divided by 16, with code 15 at an average of 240. The engaged flag is high exactly when the level is not 0.
- R7: A strobe seen in S_IDLE with enable high updates the level on the third rising edge after the capturing edge. A strobe seen in any other state is ignored.
- R8: While enable is low, the integrator, demand, average and level are cleared. The engaged flag is low and strobes are ignored.
- R9: When the temperature stays below the threshold, the level returns to code 0 and the engaged flag drops.
- R10: The threshold input selects the trip temperature, for example 83, 85 or 87 degrees. The same readings give different outputs for different thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Loop enable; low holds the loop cleared |
| strobe_i | input | 1 | One-cycle sampling pulse |
| thresh_i | input | TW | Trip temperature, whole degrees |
| temps_i | input | N_SENS*TW | Packed sensor readings |
| level_o | output | LVL_W | Scaling code, 0 = 100 %, 15 = 50 % |
| engaged_o | output | 1 | High when scaling is below full voltage |

## Verification
The hardest situation to reach is the integrator freeze: the demand sits at its upper clamp while the integrator is still far below its own saturation. If the freeze is missing, the integrator winds up, but the output looks the same until the error changes sign. The stimulus reaches this state with a large error step (+30) from a cleared loop, repeated until the average saturates. It then drops the error to -2. The level must then fall quickly toward 0 rather than stay near 15. A second hard case is a strobe arriving mid-sequence. The bench holds the strobe high into S_PI and checks that only one update happens.

// File: rtl/tpi_pkg.sv
package tpi_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PI    = 2'd1,
        S_FILT  = 2'd2,
        S_QUANT = 2'd3
    } tpi_state_e;
endpackage

// File: rtl/tpi_hot_select.sv
module tpi_hot_select #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N*W-1:0] temps_i,
    output logic [W-1:0]   hot_o
);
    always_comb begin
        hot_o = temps_i[W-1:0];
        for (int k = 1; k < N; k++) begin
            if (temps_i[k*W +: W] > hot_o) begin
                hot_o = temps_i[k*W +: W];
            end
        end
    end
endmodule

// File: rtl/tpi_lpf.sv
module tpi_lpf #(
    parameter int W = 8
) (
    input  logic [W-1:0] avg_i,
    input  logic [W-1:0] target_i,
    output logic [W-1:0] avg_next_o
);
    localparam int DW = W + 2;

    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] step;
    logic signed [DW-1:0] sum;

    always_comb begin
        diff = $signed({2'b00, target_i}) - $signed({2'b00, avg_i});
        if (diff > 0) begin
            step = (diff + DW'(3)) >>> 2;
        end else begin
            step = diff >>> 2;
        end
        sum        = $signed({2'b00, avg_i}) + step;
        avg_next_o = W'(sum);
    end
endmodule

// File: rtl/thermal_pi_ctrl.sv
module thermal_pi_ctrl
    import tpi_pkg::*;
#(
    parameter int N_SENS = 4,
    parameter int TW     = 8,
    parameter int LVL_W  = 4,
    parameter int FRAC   = 4,
    parameter int KP     = 10
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic                 strobe_i,
    input  logic [TW-1:0]        thresh_i,
    input  logic [N_SENS*TW-1:0] temps_i,
    output logic [LVL_W-1:0]     level_o,
    output logic                 engaged_o
);
    localparam int U_W     = LVL_W + FRAC;
    localparam int ERR_W   = TW + 1;
    localparam int DEM_W   = ERR_W + $clog2(KP + 1) + 1;
    localparam int LVL_MAX = (1 << LVL_W) - 1;
    localparam int FULL    = LVL_MAX << FRAC;
    localparam logic [U_W-1:0]          FULL_U = U_W'(FULL);
    localparam logic signed [DEM_W-1:0] FULL_S = DEM_W'(FULL);
    localparam logic signed [DEM_W-1:0] KP_S   = DEM_W'(KP);

    tpi_state_e state_q, state_d;

    logic [TW-1:0]             hot;
    logic signed [ERR_W-1:0]   err_d, err_q;
    logic signed [DEM_W-1:0]   err_ext, integ_ext, demand, isum;
    logic [U_W-1:0]            integ_q, integ_next, u_q, u_next, avg_q, avg_next;
    logic                      freeze;
    logic [LVL_W-1:0]          level_q;
    logic                      engaged_q;

    tpi_hot_select #(.N(N_SENS), .W(TW)) i_hot (
        .temps_i (temps_i),
        .hot_o   (hot)
    );

    tpi_lpf #(.W(U_W)) i_lpf (
        .avg_i      (avg_q),
        .target_i   (u_q),
        .avg_next_o (avg_next)
    );

    // error, demand and integrator arithmetic
    always_comb begin
        err_d     = $signed({1'b0, hot}) - $signed({1'b0, thresh_i});
        err_ext   = DEM_W'(err_q);
        integ_ext = $signed({{(DEM_W-U_W){1'b0}}, integ_q});
        demand    = err_ext * KP_S + integ_ext;
        if (demand <= 0) begin
            u_next = '0;
        end else if (demand >= FULL_S) begin
            u_next = FULL_U;
        end else begin
            u_next = U_W'(demand);
        end
        isum = integ_ext + err_ext;
        if (isum <= 0) begin
            integ_next = '0;
        end else if (isum >= FULL_S) begin
            integ_next = FULL_U;
        end else begin
            integ_next = U_W'(isum);
        end
        freeze = ((u_q == FULL_U) && (err_q > 0)) || ((u_q == '0) && (err_q < 0));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (strobe_i) state_d = S_PI;
            S_PI:    state_d = S_FILT;
            S_FILT:  state_d = S_QUANT;
            S_QUANT: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else if (!en_i) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // loop datapath registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q   <= '0;
            integ_q <= '0;
            u_q     <= '0;
            avg_q   <= '0;
        end else if (!en_i) begin
            err_q   <= '0;
            integ_q <= '0;
            u_q     <= '0;
            avg_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (strobe_i) err_q <= err_d;
                S_PI: begin
                    u_q <= u_next;
                    if (!freeze) integ_q <= integ_next;
                end
                S_FILT:  avg_q <= avg_next;
                S_QUANT: ;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            level_q   <= '0;
            engaged_q <= 1'b0;
        end else if (!en_i) begin
            level_q   <= '0;
            engaged_q <= 1'b0;
        end else if (state_q == S_QUANT) begin
            level_q   <= avg_q[U_W-1:FRAC];
            engaged_q <= |avg_q[U_W-1:FRAC];
        end
    end

    assign level_o   = level_q;
    assign engaged_o = engaged_q;

    // assertions
    a_r6_engaged_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        engaged_q == (level_q != '0));

    a_r4_integ_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && state_q == S_PI && u_q == FULL_U && err_q > 0)
        |=> ($stable(integ_q) || integ_q == '0));

    a_r7_level_only_in_quant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != S_QUANT) |=> ($stable(level_q) || level_q == '0));

    a_r7_sequence: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && state_q == S_PI) |=> (state_q == S_FILT || state_q == S_IDLE));

    a_r8_disabled_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (level_q == '0 && !engaged_q && state_q == S_IDLE));

    a_r5_avg_toward_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && state_q == S_FILT && u_q >= avg_q)
        |=> ((avg_q <= $past(u_q) && avg_q >= $past(avg_q)) || avg_q == '0));
endmodule

// File: tb/test_thermal_pi_ctrl.sv
module test_thermal_pi_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        strobe = 1'b0;
    logic [7:0]  thresh = 8'd85;
    logic [31:0] temps = '0;
    logic [3:0]  level;
    logic        engaged;

    int n_total = 0;
    int n_pass  = 0;
    int n_fail  = 0;
    int m_integ = 0;
    int m_u     = 0;
    int m_avg   = 0;
    int s_tmp[4];

    always #2 clk = ~clk;

    thermal_pi_ctrl i_thermal_pi_ctrl (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .en_i      (en),
        .strobe_i  (strobe),
        .thresh_i  (thresh),
        .temps_i   (temps),
        .level_o   (level),
        .engaged_o (engaged)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_total++;
        if (act == exp) begin
            n_pass++;
        end else begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp240(int v);
        if (v < 0) return 0;
        if (v > 240) return 240;
        return v;
    endfunction

    // reference model built from R3, R4, R5
    task automatic model_step(int err);
        int dem;
        int nu;
        int d;
        bit frz;
        dem = 10 * err + m_integ;
        nu  = clamp240(dem);
        frz = (m_u == 240 && err > 0) || (m_u == 0 && err < 0);
        if (!frz) m_integ = clamp240(m_integ + err);
        m_u = nu;
        d = m_u - m_avg;
        if (d > 0) m_avg = m_avg + (d + 3) / 4;
        else       m_avg = m_avg - ((-d + 3) / 4);
    endtask

    task automatic set_temps(int a, int b, int c, int d);
        s_tmp[0] = a; s_tmp[1] = b; s_tmp[2] = c; s_tmp[3] = d;
        temps = {d[7:0], c[7:0], b[7:0], a[7:0]};
    endtask

    task automatic do_sample(string req, int thr, bit extra, bit lat);
        int hot;
        int prev;
        hot = s_tmp[0];
        for (int k = 1; k < 4; k++) if (s_tmp[k] > hot) hot = s_tmp[k];
        prev = m_avg / 16;
        model_step(hot - thr);
        @(negedge clk); thresh = thr[7:0]; strobe = 1'b1;
        @(negedge clk); strobe = extra;
        @(negedge clk); strobe = 1'b0;
        @(negedge clk);
        if (lat) chk("R7", "level one edge before update", int'(level), prev);
        @(negedge clk);
        chk(req, "level", int'(level), m_avg / 16);
        chk(req, "engaged", int'(engaged), (m_avg / 16) != 0);
        @(negedge clk);
    endtask

    task automatic clear_loop();
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        @(negedge clk); en = 1'b1;
        m_integ = 0; m_u = 0; m_avg = 0;
    endtask

    task automatic t_reset();
        chk("R1", "level after reset", int'(level), 0);
        chk("R1", "engaged after reset", int'(engaged), 0);
    endtask

    task automatic t_below();
        set_temps(80, 78, 79, 75);
        for (int i = 0; i < 3; i++) do_sample("R3", 85, 1'b0, 1'b0);
        chk("R3", "below threshold level", int'(level), 0);
    endtask

    task automatic t_latency();
        clear_loop();
        set_temps(95, 60, 60, 60);
        do_sample("R7", 85, 1'b0, 1'b1);
        chk("R7", "first step level", int'(level), 1);
    endtask

    task automatic t_busy_strobe();
        clear_loop();
        set_temps(105, 50, 50, 50);
        do_sample("R7", 85, 1'b1, 1'b1);
        chk("R7", "single update despite busy strobe", int'(level), 3);
    endtask

    task automatic t_hot_select();
        clear_loop();
        set_temps(70, 70, 70, 96);
        do_sample("R2", 85, 1'b0, 1'b0);
        set_temps(99, 60, 62, 61);
        do_sample("R2", 85, 1'b0, 1'b0);
        set_temps(99, 10, 20, 30);
        do_sample("R2", 85, 1'b0, 1'b0);
    endtask

    task automatic t_windup();
        clear_loop();
        set_temps(115, 90, 100, 80);
        for (int i = 0; i < 24; i++) do_sample("R4", 85, 1'b0, 1'b0);
        chk("R6", "saturated level code 15", int'(level), 15);
        set_temps(83, 70, 70, 70);
        for (int i = 0; i < 10; i++) do_sample("R4", 85, 1'b0, 1'b0);
        chk("R4", "no windup after sign change", int'(level) < 6, 1);
    endtask

    task automatic t_cool();
        set_temps(40, 42, 41, 39);
        for (int i = 0; i < 30; i++) do_sample("R9", 85, 1'b0, 1'b0);
        chk("R9", "cooled level", int'(level), 0);
        chk("R9", "cooled engaged", int'(engaged), 0);
    endtask

    task automatic t_thresholds();
        int res[3];
        int thr_list[3] = '{83, 85, 87};
        for (int j = 0; j < 3; j++) begin
            clear_loop();
            set_temps(86, 80, 80, 80);
            for (int i = 0; i < 6; i++) do_sample("R10", thr_list[j], 1'b0, 1'b0);
            res[j] = int'(level);
        end
        chk("R10", "83 vs 85 differ", res[0] != res[1], 1);
        chk("R10", "87 stays off", res[2], 0);
    endtask

    task automatic t_enable();
        clear_loop();
        set_temps(110, 60, 60, 60);
        for (int i = 0; i < 3; i++) do_sample("R8", 85, 1'b0, 1'b0);
        chk("R8", "engaged before disable", int'(engaged), 1);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R8", "level cleared", int'(level), 0);
        chk("R8", "engaged cleared", int'(engaged), 0);
        strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8", "strobe ignored while disabled", int'(level), 0);
        en = 1'b1;
        m_integ = 0; m_u = 0; m_avg = 0;
        set_temps(85, 60, 60, 60);
        do_sample("R8", 85, 1'b0, 1'b0);
        set_temps(95, 60, 60, 60);
        do_sample("R8", 85, 1'b0, 1'b0);
        chk("R8", "restart from clean state", int'(level), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL R7 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        set_temps(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        en = 1'b1;
        t_below();
        t_latency();
        t_busy_strobe();
        t_hot_select();
        t_windup();
        t_cool();
        t_thresholds();
        t_enable();
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule